// File: doc/BRIEF.md
# Condition Flag Update and Condition Evaluation Unit

This block sits next to a 32-bit signal-processing ALU. Each cycle it may receive one finished result: the operation class, the index of the register the result goes to, the integer result carried to one extra bit, a carry bit, and the floating-point result with its overflow and underflow indications. It decides whether the seven condition flags held in the low bits of the status register change. When they do, it computes their new values. Some cases take the flags from the exact, unrounded result. Other cases take them from the value as it is stored in the destination register.

The same block answers condition queries for conditional instructions. A 5-bit condition code selects one of twenty tests on the current flags: always, unsigned and signed comparisons, and single-flag tests. An unconditional request overrides the code. Any code outside the usable set answers false and raises a one-cycle illegal indication.

Top module: `ccf_unit`

## Requirements
- R1: After reset, `st_flags` is all zero and `cond_illegal` is low.
- R2: The flags change only when `res_valid` is high and one of two cases holds. Either `res_dst` is in 0..7, or the class is a compare (`res_opc` 3 = integer compare, 4 = bit test, 5 = float compare). Integer (0), logical (1) and float (2) results sent to any other register leave `st_flags` unchanged, and so do class codes 6 and 7.
- R3: Flag bit order in `st_flags`, from bit 0 upward: C, V, Z, N, UF, LV, LUF.
- R4: Integer and integer-compare results set C = `res_carry`, V = (`res_int[32]` != `res_int[31]`) and UF = 0. For compares, or when V is 1, N = `res_int[32]` and Z = (all 33 bits zero). Otherwise N = `res_int[31]` and Z = (low 32 bits zero).
- R5: Logical and bit-test results set C = V = UF = 0, N = `res_int[31]` and Z = (low 32 bits zero).
- R6: Float and float-compare results set C = 0, V = `flt_ovf` and UF = `flt_unf`. When either of those is set, Z = 0 and N = `flt_man[31]`. Otherwise Z = (`flt_exp` == 8'h80) and N = `flt_man[31]` AND NOT Z.
- R7: LV and LUF are sticky. On an update they become (old value OR new V) and (old value OR new UF). Nothing but a status write clears them.
- R8: When `st_wr` is high, `st_flags` takes `st_wdata` at the next edge, and this has priority over a result update in the same cycle.
- R9: Flag changes appear one clock edge after the result. `cond_true` is combinational and, in the cycle a result arrives, uses the old flags.
- R10: Code mapping, where C, V, Z, N, UF, LV, LUF are the flag values:

  | Code | Result |
  |------|--------|
  | 0 | 1 |
  | 1 | C |
  | 2 | C\|Z |
  | 3 | !C&!Z |
  | 4 | !C |
  | 5 | Z |
  | 6 | !Z |
  | 7 | N |
  | 8 | N\|Z |
  | 9 | !N&!Z |
  | 10 | !N |
  | 12 | !V |
  | 13 | V |
  | 14 | !UF |
  | 15 | UF |
  | 16 | !LV |
  | 17 | LV |
  | 18 | !LUF |
  | 19 | LUF |
  | 20 | Z\|UF |

- R11: When `cond_uncond` is high, `cond_true` is 1 whatever the code, and `cond_illegal` stays low.
- R12: Code 11 and codes 21..31 give `cond_true` = 0. A `cond_req` carrying such a code without `cond_uncond` raises `cond_illegal` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A result is presented this cycle |
| res_opc | input | 3 | Operation class |
| res_dst | input | 5 | Destination register index |
| res_int | input | 33 | Integer/logical result, one bit beyond 32 |
| res_carry | input | 1 | Carry or borrow out |
| flt_exp | input | 8 | Float result exponent |
| flt_man | input | 32 | Float result sign (bit 31) and fraction |
| flt_ovf | input | 1 | Float overflow |
| flt_unf | input | 1 | Float underflow |
| st_wr | input | 1 | Explicit status flag write |
| st_wdata | input | 7 | Flag value for the status write |
| cond_req | input | 1 | A conditional instruction asks for a decision |
| cond_code | input | 5 | Condition code |
| cond_uncond | input | 1 | Unconditional form, forces true |
| st_flags | output | 7 | Current condition flags |
| cond_true | output | 1 | Condition decision on the current flags |
| cond_illegal | output | 1 | Unusable code was requested last cycle |

## Verification
`cond_true` is due in the same cycle as its code. The bench drives on the falling edge and compares it one time unit later, against a model state that has not yet absorbed that cycle's result. `st_flags` and `cond_illegal` each pass through one register, so they are compared at the next falling edge after the driving one. The bench advances its model only after the compare on `cond_true`, so its ordering follows the design's one-edge latency.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    typedef enum logic [2:0] {
        OPC_INT   = 3'd0,
        OPC_LOGIC = 3'd1,
        OPC_FLT   = 3'd2,
        OPC_CMPI  = 3'd3,
        OPC_TSTB  = 3'd4,
        OPC_CMPF  = 3'd5
    } opc_e;

    // first member is the most significant bit: carry lands on bit 0
    typedef struct packed {
        logic luf;
        logic lv;
        logic uf;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam int          FLAG_N   = 7;
    localparam int          CODE_W   = 5;
    localparam logic [4:0]  CC_RSVD  = 5'd11;
    localparam logic [4:0]  CC_LAST  = 5'd20;

    function automatic logic opc_is_cmp(input logic [2:0] opc);
        return (opc == OPC_CMPI) || (opc == OPC_TSTB) || (opc == OPC_CMPF);
    endfunction

endpackage

// File: rtl/ccf_flag_calc.sv
module ccf_flag_calc
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EXP_W  = 8
) (
    input  logic [2:0]        opc,
    input  logic [DATA_W:0]   res_int,
    input  logic              res_carry,
    input  logic [EXP_W-1:0]  flt_exp,
    input  logic [DATA_W-1:0] flt_man,
    input  logic              flt_ovf,
    input  logic              flt_unf,
    output flags_t            cand,
    output logic              known
);
    localparam logic [EXP_W-1:0] EXP_ZERO = {1'b1, {(EXP_W-1){1'b0}}};

    logic int_ovf;
    logic low_zero;
    logic wide_zero;
    logic exact_int;
    logic flt_exc;
    logic flt_zero;

    assign int_ovf   = res_int[DATA_W] ^ res_int[DATA_W-1];
    assign low_zero  = (res_int[DATA_W-1:0] == '0);
    assign wide_zero = low_zero && !res_int[DATA_W];
    assign flt_exc   = flt_ovf | flt_unf;
    assign flt_zero  = (flt_exp == EXP_ZERO);

    always_comb begin
        cand      = '0;
        known     = 1'b1;
        exact_int = 1'b0;
        case (opc)
            OPC_INT, OPC_CMPI: begin
                exact_int = (opc == OPC_CMPI) || int_ovf;
                cand.c    = res_carry;
                cand.v    = int_ovf;
                cand.n    = exact_int ? res_int[DATA_W] : res_int[DATA_W-1];
                cand.z    = exact_int ? wide_zero : low_zero;
            end
            OPC_LOGIC, OPC_TSTB: begin
                cand.n = res_int[DATA_W-1];
                cand.z = low_zero;
            end
            OPC_FLT, OPC_CMPF: begin
                cand.v  = flt_ovf;
                cand.uf = flt_unf;
                cand.z  = !flt_exc && flt_zero;
                cand.n  = flt_man[DATA_W-1] && (flt_exc || !flt_zero);
            end
            default: known = 1'b0;
        endcase
    end

endmodule

// File: rtl/ccf_cond_eval.sv
module ccf_cond_eval
    import ccf_pkg::*;
(
    input  flags_t             f,
    input  logic [CODE_W-1:0]  code,
    input  logic               uncond,
    output logic               truth,
    output logic               bad
);
    logic raw;
    logic unusable;

    assign unusable = (code == CC_RSVD) || (code > CC_LAST);

    always_comb begin
        case (code)
            5'd0:    raw = 1'b1;
            5'd1:    raw = f.c;
            5'd2:    raw = f.c | f.z;
            5'd3:    raw = !(f.c | f.z);
            5'd4:    raw = !f.c;
            5'd5:    raw = f.z;
            5'd6:    raw = !f.z;
            5'd7:    raw = f.n;
            5'd8:    raw = f.n | f.z;
            5'd9:    raw = !(f.n | f.z);
            5'd10:   raw = !f.n;
            5'd12:   raw = !f.v;
            5'd13:   raw = f.v;
            5'd14:   raw = !f.uf;
            5'd15:   raw = f.uf;
            5'd16:   raw = !f.lv;
            5'd17:   raw = f.lv;
            5'd18:   raw = !f.luf;
            5'd19:   raw = f.luf;
            5'd20:   raw = f.z | f.uf;
            default: raw = 1'b0;
        endcase
    end

    assign truth = uncond | raw;
    assign bad   = !uncond && unusable;

endmodule

// File: rtl/ccf_unit.sv
module ccf_unit
    import ccf_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int EXP_W    = 8,
    parameter int DST_W    = 5,
    parameter int EXT_BASE = 0,
    parameter int EXT_CNT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [2:0]        res_opc,
    input  logic [DST_W-1:0]  res_dst,
    input  logic [DATA_W:0]   res_int,
    input  logic              res_carry,
    input  logic [EXP_W-1:0]  flt_exp,
    input  logic [DATA_W-1:0] flt_man,
    input  logic              flt_ovf,
    input  logic              flt_unf,
    input  logic              st_wr,
    input  logic [6:0]        st_wdata,
    input  logic              cond_req,
    input  logic [4:0]        cond_code,
    input  logic              cond_uncond,
    output logic [6:0]        st_flags,
    output logic              cond_true,
    output logic              cond_illegal
);
    localparam int EXT_END = EXT_BASE + EXT_CNT;

    typedef struct packed {
        flags_t flags;
        logic   illegal;
    } state_t;

    state_t st_d, st_q;
    flags_t cand;
    logic   cand_known;
    logic   in_grp;
    logic   upd;
    logic   code_bad;

    ccf_flag_calc #(
        .DATA_W (DATA_W),
        .EXP_W  (EXP_W)
    ) u_calc (
        .opc       (res_opc),
        .res_int   (res_int),
        .res_carry (res_carry),
        .flt_exp   (flt_exp),
        .flt_man   (flt_man),
        .flt_ovf   (flt_ovf),
        .flt_unf   (flt_unf),
        .cand      (cand),
        .known     (cand_known)
    );

    ccf_cond_eval u_eval (
        .f      (st_q.flags),
        .code   (cond_code),
        .uncond (cond_uncond),
        .truth  (cond_true),
        .bad    (code_bad)
    );

    assign in_grp = (int'(res_dst) >= EXT_BASE) && (int'(res_dst) < EXT_END);
    assign upd    = res_valid && cand_known && (in_grp || opc_is_cmp(res_opc));

    always_comb begin
        st_d = st_q;
        if (st_wr) begin
            st_d.flags = flags_t'(st_wdata);
        end else if (upd) begin
            st_d.flags.c   = cand.c;
            st_d.flags.v   = cand.v;
            st_d.flags.z   = cand.z;
            st_d.flags.n   = cand.n;
            st_d.flags.uf  = cand.uf;
            st_d.flags.lv  = st_q.flags.lv  | cand.v;
            st_d.flags.luf = st_q.flags.luf | cand.uf;
        end
        st_d.illegal = cond_req && code_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_flags     = st_q.flags;
    assign cond_illegal = st_q.illegal;

endmodule

// File: rtl/ccf_unit_chk.sv
module ccf_unit_chk #(
    parameter int DST_W    = 5,
    parameter int EXT_BASE = 0,
    parameter int EXT_CNT  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_valid,
    input logic [2:0]       res_opc,
    input logic [DST_W-1:0] res_dst,
    input logic             st_wr,
    input logic [6:0]       st_wdata,
    input logic             cond_req,
    input logic [4:0]       cond_code,
    input logic             cond_uncond,
    input logic [6:0]       st_flags,
    input logic             cond_true,
    input logic             cond_illegal
);
    logic out_grp;
    logic plain_cls;
    logic bad_req;

    assign out_grp   = (int'(res_dst) < EXT_BASE) || (int'(res_dst) >= EXT_BASE + EXT_CNT);
    assign plain_cls = (res_opc == 3'd0) || (res_opc == 3'd1) || (res_opc == 3'd2);
    assign bad_req   = cond_req && !cond_uncond && ((cond_code == 5'd11) || (cond_code > 5'd20));

    AST_OUTSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !st_wr && plain_cls && out_grp) |=> $stable(st_flags)); // R2
    AST_STWR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> (st_flags == $past(st_wdata))); // R8
    AST_LV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_flags[5] && !st_wr) |=> st_flags[5]); // R7
    AST_LUF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_flags[6] && !st_wr) |=> st_flags[6]); // R7
    AST_UNCOND_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        cond_uncond |-> cond_true); // R11
    AST_UNCOND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cond_uncond |=> !cond_illegal); // R11
    AST_BAD_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |-> !cond_true); // R12
    AST_BAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> cond_illegal); // R12
    AST_ILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cond_illegal |-> $past(bad_req)); // R12

endmodule

bind ccf_unit ccf_unit_chk #(
    .DST_W    (DST_W),
    .EXT_BASE (EXT_BASE),
    .EXT_CNT  (EXT_CNT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_valid    (res_valid),
    .res_opc      (res_opc),
    .res_dst      (res_dst),
    .st_wr        (st_wr),
    .st_wdata     (st_wdata),
    .cond_req     (cond_req),
    .cond_code    (cond_code),
    .cond_uncond  (cond_uncond),
    .st_flags     (st_flags),
    .cond_true    (cond_true),
    .cond_illegal (cond_illegal)
);

// File: tb/ccf_unit_bench.sv
module ccf_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [2:0]  res_opc = '0;
    logic [4:0]  res_dst = '0;
    logic [32:0] res_int = '0;
    logic        res_carry = 1'b0;
    logic [7:0]  flt_exp = '0;
    logic [31:0] flt_man = '0;
    logic        flt_ovf = 1'b0;
    logic        flt_unf = 1'b0;
    logic        st_wr = 1'b0;
    logic [6:0]  st_wdata = '0;
    logic        cond_req = 1'b0;
    logic [4:0]  cond_code = '0;
    logic        cond_uncond = 1'b0;
    logic [6:0]  st_flags;
    logic        cond_true;
    logic        cond_illegal;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [6:0] model = '0;
    logic       exp_ill = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccf_unit u_ccf_unit (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_opc(res_opc),
        .res_dst(res_dst), .res_int(res_int), .res_carry(res_carry),
        .flt_exp(flt_exp), .flt_man(flt_man), .flt_ovf(flt_ovf), .flt_unf(flt_unf),
        .st_wr(st_wr), .st_wdata(st_wdata), .cond_req(cond_req),
        .cond_code(cond_code), .cond_uncond(cond_uncond), .st_flags(st_flags),
        .cond_true(cond_true), .cond_illegal(cond_illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // bits: 0 C, 1 V, 2 Z, 3 N, 4 UF, 5 LV, 6 LUF
    function automatic logic [6:0] ref_next(input logic [6:0] cur);
        logic [6:0] f;
        logic ov;
        f = cur;
        if (st_wr) return st_wdata;
        if (!res_valid || res_opc > 3'd5) return cur;
        if (!(res_opc >= 3'd3 || res_dst < 5'd8)) return cur;
        case (res_opc)
            3'd0, 3'd3: begin
                ov = res_int[32] != res_int[31];
                f[0] = res_carry; f[1] = ov; f[4] = 1'b0;
                if (res_opc == 3'd3 || ov) begin
                    f[3] = res_int[32]; f[2] = (res_int == 33'd0);
                end else begin
                    f[3] = res_int[31]; f[2] = (res_int[31:0] == 32'd0);
                end
            end
            3'd1, 3'd4: begin
                f[0] = 1'b0; f[1] = 1'b0; f[4] = 1'b0;
                f[3] = res_int[31]; f[2] = (res_int[31:0] == 32'd0);
            end
            default: begin
                f[0] = 1'b0; f[1] = flt_ovf; f[4] = flt_unf;
                if (flt_ovf || flt_unf) begin
                    f[2] = 1'b0; f[3] = flt_man[31];
                end else begin
                    f[2] = (flt_exp == 8'h80); f[3] = flt_man[31] && !f[2];
                end
            end
        endcase
        f[5] = cur[5] | f[1];
        f[6] = cur[6] | f[4];
        return f;
    endfunction

    function automatic logic ref_cond(input logic [6:0] f);
        logic c, v, z, n, uf, lv, luf;
        {luf, lv, uf, n, z, v, c} = f;
        if (cond_uncond) return 1'b1;
        case (cond_code)
            5'd0: return 1'b1;
            5'd1: return c;
            5'd2: return c | z;
            5'd3: return !c && !z;
            5'd4: return !c;
            5'd5: return z;
            5'd6: return !z;
            5'd7: return n;
            5'd8: return n | z;
            5'd9: return !n && !z;
            5'd10: return !n;
            5'd12: return !v;
            5'd13: return v;
            5'd14: return !uf;
            5'd15: return uf;
            5'd16: return !lv;
            5'd17: return lv;
            5'd18: return !luf;
            5'd19: return luf;
            5'd20: return z | uf;
            default: return 1'b0;
        endcase
    endfunction

    // called at a falling edge with inputs already driven
    task automatic step(input string req);
        #1;
        chk({req, " R9/R10 cond_true on old flags"}, {31'd0, cond_true}, {31'd0, ref_cond(model)});
        exp_ill = cond_req && !cond_uncond && (cond_code == 5'd11 || cond_code > 5'd20);
        model   = ref_next(model);
        @(posedge clk);
        @(negedge clk);
        chk({req, " R3 st_flags"}, {25'd0, st_flags}, {25'd0, model});
        chk({req, " R12 cond_illegal"}, {31'd0, cond_illegal}, {31'd0, exp_ill});
        res_valid = 1'b0; st_wr = 1'b0; cond_req = 1'b0; cond_uncond = 1'b0;
    endtask

    task automatic put_int(input logic [2:0] opc, input logic [4:0] dst,
                           input logic [32:0] r, input logic cy);
        res_valid = 1'b1; res_opc = opc; res_dst = dst; res_int = r; res_carry = cy;
    endtask

    task automatic put_flt(input logic [2:0] opc, input logic [4:0] dst, input logic [7:0] e,
                           input logic [31:0] m, input logic ov, input logic un);
        res_valid = 1'b1; res_opc = opc; res_dst = dst;
        flt_exp = e; flt_man = m; flt_ovf = ov; flt_unf = un;
    endtask

    task automatic ask(input logic [4:0] code, input logic unc);
        cond_req = 1'b1; cond_code = code; cond_uncond = unc;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset flags", {25'd0, st_flags}, 32'd0);
        chk("R1 reset illegal", {31'd0, cond_illegal}, 32'd0);

        // R9: zero result and EQ query in the same cycle sees old Z=0
        put_int(3'd0, 5'd0, 33'd0, 1'b0); ask(5'd5, 1'b0);
        step("R9 same-cycle");
        chk("R4 zero result sets Z", {31'd0, st_flags[2]}, 32'd1);
        ask(5'd5, 1'b0);
        step("R9 next-cycle EQ");

        // R4: overflow, low 32 zero but exact result nonzero
        put_int(3'd0, 5'd2, 33'h1_0000_0000, 1'b1);
        step("R4 overflow exact");
        chk("R4 overflow Z from exact", {31'd0, st_flags[2]}, 32'd0);
        chk("R7 LV set with V", {31'd0, st_flags[5]}, 32'd1);

        // R5: same pattern as logical: stored format gives Z=1
        put_int(3'd1, 5'd3, 33'h1_0000_0000, 1'b1);
        step("R5 logical stored");
        chk("R7 LV kept by later update", {31'd0, st_flags[5]}, 32'd1);

        // R2: outside group no effect, compare to outside group updates
        put_int(3'd0, 5'd9, 33'h0_8000_0000, 1'b0);
        step("R2 outside group");
        put_int(3'd3, 5'd20, 33'h1_8000_0000, 1'b1);
        step("R2 compare any dst");

        // R6: float underflow with zero exponent
        put_flt(3'd2, 5'd7, 8'h80, 32'h8000_0000, 1'b0, 1'b1);
        step("R6 float underflow");
        put_flt(3'd5, 5'd30, 8'h80, 32'h8000_0000, 1'b0, 1'b0);
        step("R6 float compare zero");

        // R8: status write wins over a same-cycle update and clears sticky bits
        put_int(3'd0, 5'd1, 33'h1_0000_0000, 1'b1);
        st_wr = 1'b1; st_wdata = 7'b000_0101;
        step("R8 status write");

        // R11, R12
        ask(5'd11, 1'b1); step("R11 uncond reserved");
        ask(5'd11, 1'b0); step("R12 reserved code");
        step("R12 pulse ends");
        ask(5'd27, 1'b0); step("R12 high code");

        for (int i = 0; i < N_RANDOM; i++) begin
            int sel = $urandom_range(0, 9);
            res_valid = ($urandom_range(0, 3) != 0);
            res_opc   = 3'($urandom_range(0, 7));
            res_dst   = 5'($urandom_range(0, 31));
            case ($urandom_range(0, 3))
                0: res_int = 33'd0;
                1: res_int = {1'b1, 32'd0};
                2: res_int = {1'($urandom), $urandom};
                default: res_int = 33'($urandom_range(0, 15));
            endcase
            res_carry = 1'($urandom);
            flt_exp   = ($urandom_range(0, 2) == 0) ? 8'h80 : 8'($urandom);
            flt_man   = $urandom;
            flt_ovf   = ($urandom_range(0, 5) == 0);
            flt_unf   = ($urandom_range(0, 5) == 0);
            st_wr     = (sel == 0);
            st_wdata  = 7'($urandom);
            cond_req  = ($urandom_range(0, 1) == 1);
            cond_code = 5'($urandom_range(0, 23));
            cond_uncond = (sel == 1);
            step("R10 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule